// File: doc/BRIEF.md
# Host Command and Interrupt Mask Register

This block is the 32-bit command and control word through which host software drives a network controller. The low byte is a command slot. The host writes a nonzero command code into it. The command engine sees that code on a valid/ready pair and clears the slot when it takes the command. The top byte holds six per-event interrupt masks, a write-only software interrupt trigger and a global interrupt mask. The two middle bytes are reserved and read as zero.

Six internal event strobes each latch a sticky pending flag. A software trigger latches a seventh flag. The host clears flags by pulsing the matching bits of a clear input. A registered, active-low interrupt pin is asserted while the global mask is clear and at least one pending flag is not masked. The global mask overrides everything else. A single write that sets both the global mask and the software trigger produces no interrupt.

Back-pressure on the command slot works as follows. The code stays on `cmd_code` with `cmd_valid` high until `cmd_ready` is sampled high. The slot is then zero on the next cycle. A host write to the low byte in the same cycle as a handshake takes priority, so the new code is never dropped.

Top module: `hcim_ctrl_word`

## Requirements
- R1: After reset, `host_rdata` is 0, `pend_o` is 0, `cmd_valid` is 0 and `irq_n` is 1.
- R2: A write with `host_be[3]` set stores wdata[31:26] as event masks and wdata[24] as the global mask. Both read back at the same positions, and bits 23:8 always read 0.
- R3: Bit 25 of `host_rdata` always reads 0. Writing 0 to bit 25 has no effect.
- R4: A high `evt_strobe[i]` sets `pend_o[i]` at the next clock edge. Event index i is masked by word bit 26+i: 0 is flow-control pause, 1 early receive, 2 receive not ready, 3 command unit idle, 4 frame received and 5 command complete. `pend_o[6]` is the software flag.
- R5: Pending flags are sticky. A high `pend_clr[i]` clears flag i at the next edge. A set in the same cycle wins over the clear.
- R6: `irq_n` is registered. It goes low one cycle after a state where the global mask is 0 and either an event flag with a clear mask bit or the software flag is pending. Otherwise it is high.
- R7: While the global mask is 1, `irq_n` is high from the next cycle on, whatever flags and event masks hold.
- R8: A set event mask bit blocks only its own event. Other unmasked pending events still assert `irq_n`.
- R9: A byte-3 write with bit 25 = 1 and bit 24 = 0 sets `pend_o[6]`. A write with bits 25 and 24 both 1 leaves `pend_o[6]` unchanged.
- R10: A write with `host_be[0]` set stores wdata[7:0] as the command code. The code reads back in bits 7:0 and drives `cmd_code`, and `cmd_valid` is high while the code is nonzero.
- R11: With `cmd_valid` high, the code holds while `cmd_ready` is low. It is cleared to 0 at the edge where `cmd_ready` is high.
- R12: When a byte-0 host write and a command handshake share a cycle, the written code is kept.
- R13: Only the bytes whose enable bit is set are updated by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_be | input | 4 | Byte enables for the write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Current register word |
| evt_strobe | input | 6 | Event strobes, one per event |
| pend_clr | input | 7 | Pending-flag clear bits |
| pend_o | output | 7 | Pending flags (bit 6 software) |
| cmd_valid | output | 1 | Command slot holds a nonzero code |
| cmd_code | output | 8 | Command code to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The properties assume that every input is synchronous to `clk` and stable around its rising edge. They place no limit on pulse widths or on how a host write overlaps a handshake, strobes or clears. `cmd_ready` may be high when no command is pending. The stimulus changes every input on the falling edge only. It mixes directed sequences with random inputs that include simultaneous set and clear, a write during a handshake, and writes that set both the trigger bit and the global mask.

// File: rtl/hcim_pkg.sv
package hcim_pkg;
  parameter int WORD_W    = 32;
  parameter int CMD_W     = 8;
  parameter int EVT_N     = 6;
  localparam int PEND_N    = EVT_N + 1;
  localparam int GMASK_BIT = 24;
  localparam int SWI_BIT   = GMASK_BIT + 1;
  localparam int EMASK_LSB = SWI_BIT + 1;
  localparam int BE_W      = WORD_W / 8;
  localparam int CTRL_BYTE = BE_W - 1;
endpackage

// File: rtl/hcim_cmd_slot.sv
module hcim_cmd_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_code,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] code
);
  logic [W-1:0] code_q;

  // Host load has priority over the engine's clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      code_q <= '0;
    else if (load)
      code_q <= load_code;
    else if (valid && ready)
      code_q <= '0;
  end

  assign valid = |code_q;
  assign code  = code_q;
endmodule

// File: rtl/hcim_pend_bank.sv
module hcim_pend_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    // Set beats clear so a fresh event is never lost.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag_q <= 1'b0;
      else if (set[i])
        flag_q <= 1'b1;
      else if (clr[i])
        flag_q <= 1'b0;
    end
    assign pend[i] = flag_q;
  end
endmodule

// File: rtl/hcim_irq_gen.sv
module hcim_irq_gen #(
  parameter int EVT_N = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVT_N:0] pend,
  input  logic [EVT_N-1:0] evt_mask,
  input  logic           gmask,
  output logic           irq_n
);
  logic fire;
  logic irq_n_q;

  always_comb begin
    fire = pend[EVT_N];
    for (int i = 0; i < EVT_N; i++)
      fire = fire | (pend[i] & ~evt_mask[i]);
    fire = fire & ~gmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_q <= 1'b1;
    else        irq_n_q <= ~fire;
  end

  assign irq_n = irq_n_q;
endmodule

// File: rtl/hcim_ctrl_word.sv
module hcim_ctrl_word
  import hcim_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [BE_W-1:0]     host_be,
  input  logic [WORD_W-1:0]   host_wdata,
  output logic [WORD_W-1:0]   host_rdata,
  input  logic [EVT_N-1:0]    evt_strobe,
  input  logic [PEND_N-1:0]   pend_clr,
  output logic [PEND_N-1:0]   pend_o,
  output logic                cmd_valid,
  output logic [CMD_W-1:0]    cmd_code,
  input  logic                cmd_ready,
  output logic                irq_n
);
  logic [EVT_N-1:0]  evt_mask_q;
  logic              gmask_q;
  logic              ctrl_wr;
  logic              swi_req;
  logic [PEND_N-1:0] pend_set;
  logic              unused_mid;

  assign ctrl_wr = host_wr && host_be[CTRL_BYTE];
  // Trigger only counts when the same write leaves the global mask clear.
  assign swi_req = ctrl_wr && host_wdata[SWI_BIT] && !host_wdata[GMASK_BIT];
  assign pend_set = {swi_req, evt_strobe};
  assign unused_mid = ^{host_wdata[GMASK_BIT-1:CMD_W], host_be[CTRL_BYTE-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_mask_q <= '0;
      gmask_q    <= 1'b0;
    end else if (ctrl_wr) begin
      evt_mask_q <= host_wdata[EMASK_LSB +: EVT_N];
      gmask_q    <= host_wdata[GMASK_BIT];
    end
  end

  hcim_cmd_slot #(.W(CMD_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (host_wr && host_be[0]),
    .load_code (host_wdata[CMD_W-1:0]),
    .ready     (cmd_ready),
    .valid     (cmd_valid),
    .code      (cmd_code)
  );

  hcim_pend_bank #(.N(PEND_N)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (pend_set),
    .clr   (pend_clr),
    .pend  (pend_o)
  );

  hcim_irq_gen #(.EVT_N(EVT_N)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend_o),
    .evt_mask (evt_mask_q),
    .gmask    (gmask_q),
    .irq_n    (irq_n)
  );

  always_comb begin
    host_rdata = '0;
    host_rdata[EMASK_LSB +: EVT_N] = evt_mask_q;
    host_rdata[GMASK_BIT]          = gmask_q;
    host_rdata[CMD_W-1:0]          = cmd_code;
  end
endmodule

// File: rtl/hcim_ctrl_word_chk.sv
module hcim_ctrl_word_chk
  import hcim_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                host_wr,
  input logic [BE_W-1:0]     host_be,
  input logic [WORD_W-1:0]   host_wdata,
  input logic [WORD_W-1:0]   host_rdata,
  input logic [EVT_N-1:0]    evt_strobe,
  input logic [PEND_N-1:0]   pend_clr,
  input logic [PEND_N-1:0]   pend_o,
  input logic                cmd_valid,
  input logic [CMD_W-1:0]    cmd_code,
  input logic                cmd_ready,
  input logic                irq_n,
  input logic [EVT_N-1:0]    evt_mask,
  input logic                gmask
);
  assert_swi_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[SWI_BIT] == 1'b0);

  assert_event_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_strobe) |=> ((pend_o[EVT_N-1:0] & $past(evt_strobe)) == $past(evt_strobe)));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_o & ~pend_clr)) |=> ((pend_o & $past(pend_o & ~pend_clr)) == $past(pend_o & ~pend_clr)));

  assert_irq_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(!gmask && ((|(pend_o[EVT_N-1:0] & ~evt_mask)) || pend_o[EVT_N])));

  assert_gmask_silences_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |=> irq_n);

  assert_masked_trigger_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_be[CTRL_BYTE] && host_wdata[SWI_BIT] && host_wdata[GMASK_BIT] && !pend_o[EVT_N])
    |=> !pend_o[EVT_N]);

  assert_cmd_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !(host_wr && host_be[0])) |=> (cmd_valid && $stable(cmd_code)));

  assert_cmd_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !(host_wr && host_be[0])) |=> !cmd_valid);

  assert_host_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_be[0]) |=> (cmd_code == $past(host_wdata[CMD_W-1:0])));
endmodule

bind hcim_ctrl_word hcim_ctrl_word_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_be    (host_be),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .evt_strobe (evt_strobe),
  .pend_clr   (pend_clr),
  .pend_o     (pend_o),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .cmd_ready  (cmd_ready),
  .irq_n      (irq_n),
  .evt_mask   (evt_mask_q),
  .gmask      (gmask_q)
);

// File: tb/hcim_ctrl_word_tb.sv
module hcim_ctrl_word_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [3:0]  host_be = 4'h0;
  logic [31:0] host_wdata = 32'h0;
  logic [31:0] host_rdata;
  logic [5:0]  evt_strobe = 6'h0;
  logic [6:0]  pend_clr = 7'h0;
  logic [6:0]  pend_o;
  logic        cmd_valid;
  logic [7:0]  cmd_code;
  logic        cmd_ready = 1'b0;
  logic        irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hcim_ctrl_word dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_be(host_be),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_strobe(evt_strobe),
    .pend_clr(pend_clr), .pend_o(pend_o), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_ready(cmd_ready), .irq_n(irq_n)
  );

  // Behavioural reference, updated on each rising edge from the driven inputs.
  logic [5:0] m_mask = 6'h0;
  logic       m_g = 1'b0;
  logic [6:0] m_pend = 7'h0;
  logic [7:0] m_cmd = 8'h0;
  logic       m_irq_n = 1'b1;

  always @(posedge clk) begin
    logic nxt_irq_n;
    logic swi;
    if (!rst_n) begin
      m_mask = 0; m_g = 0; m_pend = 0; m_cmd = 0; m_irq_n = 1;
    end else begin
      nxt_irq_n = !(!m_g && (((m_pend[5:0] & ~m_mask) != 0) || m_pend[6]));
      swi = 1'b0;
      if (host_wr && host_be[3]) begin
        m_mask = host_wdata[31:26];
        m_g    = host_wdata[24];
        swi    = host_wdata[25] && !host_wdata[24];
      end
      m_pend = (m_pend & ~pend_clr) | {swi, evt_strobe};
      if (host_wr && host_be[0]) m_cmd = host_wdata[7:0];
      else if (m_cmd != 0 && cmd_ready) m_cmd = 8'h0;
      m_irq_n = nxt_irq_n;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 word", host_rdata, {m_mask, 1'b0, m_g, 16'h0, m_cmd});
      chk("R4 pending", {25'h0, pend_o}, {25'h0, m_pend});
      chk("R10 valid", {31'h0, cmd_valid}, {31'h0, m_cmd != 0});
      chk("R11 code", {24'h0, cmd_code}, {24'h0, m_cmd});
      chk("R6 irq", {31'h0, irq_n}, {31'h0, m_irq_n});
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    host_wr = 1'b1; host_be = be; host_wdata = d;
    step();
    host_wr = 1'b0; host_be = 4'h0; host_wdata = 32'h0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'h0, irq_n}, 32'h1);
    rst_n = 1'b1;
    step();
    chk("R1 word", host_rdata, 32'h0);
    chk("R1 pend", {25'h0, pend_o}, 32'h0);
    chk("R1 valid", {31'h0, cmd_valid}, 32'h0);
    chk("R1 irq", {31'h0, irq_n}, 32'h1);

    wr(4'hF, 32'hFDFF_FF00);
    chk("R2 masks stored, middle zero", host_rdata, 32'hFD00_0000);
    wr(4'h8, 32'hFF00_0000);
    step();
    chk("R9 both bits no flag", {25'h0, pend_o}, 32'h0);
    chk("R3 bit25 reads zero", {31'h0, host_rdata[25]}, 32'h0);
    chk("R9 no irq", {31'h0, irq_n}, 32'h1);
    wr(4'h8, 32'h0000_0000);
    step();
    chk("R3 zero write no flag", {25'h0, pend_o}, 32'h0);

    evt_strobe = 6'h01;
    step();
    evt_strobe = 6'h00;
    chk("R4 flag 0 set", {25'h0, pend_o}, 32'h01);
    chk("R6 irq lags a cycle", {31'h0, irq_n}, 32'h1);
    step();
    chk("R6 irq asserted", {31'h0, irq_n}, 32'h0);

    wr(4'h8, 32'h0100_0000);
    step();
    chk("R7 global mask silences", {31'h0, irq_n}, 32'h1);

    wr(4'h8, 32'h0400_0000);
    step();
    chk("R8 own mask blocks", {31'h0, irq_n}, 32'h1);
    evt_strobe = 6'h20;
    step();
    evt_strobe = 6'h00;
    step();
    chk("R8 other event fires", {31'h0, irq_n}, 32'h0);

    pend_clr = 7'h21; evt_strobe = 6'h01;
    step();
    pend_clr = 7'h00; evt_strobe = 6'h00;
    chk("R5 set beats clear", {25'h0, pend_o}, 32'h01);
    pend_clr = 7'h01;
    step();
    pend_clr = 7'h00;
    chk("R5 clear", {25'h0, pend_o}, 32'h00);

    wr(4'h8, 32'h0200_0000);
    chk("R9 trigger sets flag", {25'h0, pend_o}, 32'h40);
    step();
    chk("R9 trigger irq", {31'h0, irq_n}, 32'h0);
    pend_clr = 7'h40;
    step();
    pend_clr = 7'h00;

    wr(4'h6, 32'hFFFF_FFFF);
    chk("R13 disabled bytes untouched", host_rdata, 32'h0000_0000);

    wr(4'h1, 32'h0000_0012);
    chk("R10 code loaded", {23'h0, cmd_valid, cmd_code}, 32'h112);
    chk("R10 code reads back", host_rdata, 32'h0000_0012);
    step(); step();
    chk("R11 code held", {24'h0, cmd_code}, 32'h12);
    cmd_ready = 1'b1;
    step();
    cmd_ready = 1'b0;
    chk("R11 cleared on accept", {23'h0, cmd_valid, cmd_code}, 32'h0);
    wr(4'h1, 32'h0000_0034);
    cmd_ready = 1'b1;
    wr(4'h1, 32'h0000_0056);
    cmd_ready = 1'b0;
    chk("R12 host write wins", {24'h0, cmd_code}, 32'h56);
    cmd_ready = 1'b1;
    step();
    cmd_ready = 1'b0;

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      host_wr    = (r[3:0] < 4'd3);
      host_be    = r[7:4];
      host_wdata = $urandom;
      if (r[8]) host_wdata[24] = 1'b0;
      evt_strobe = (r[11:9] == 3'd0) ? 6'($urandom) : 6'h0;
      pend_clr   = (r[14:12] < 3'd2) ? 7'($urandom) : 7'h0;
      cmd_ready  = r[15];
      step();
    end
    host_wr = 0; evt_strobe = 0; pend_clr = 0; cmd_ready = 0;
    step();
    finish_run();
  end
endmodule